// File: doc/BRIEF.md
# Timing Reference Sequence Inserter

This block sits in a video transmit path after the luma and chroma streams have been split into two parallel word streams. It takes one luma word and one chroma word per clock, together with three timing flags: horizontal blanking, vertical blanking and field. From the edges of the horizontal blanking flag it places an end-of-active-video sequence and a start-of-active-video sequence into both streams. Each sequence is four words long. The fourth word carries the field, vertical and horizontal bits, followed by four protection bits.

As an option, the block can replace every sample inside a horizontal or vertical blanking interval with the blanking level. Sequence words are never replaced. The block also has a detect mode for streams that already carry their timing sequences. In this mode the three flag inputs are ignored and no sequences are generated. The stream passes through, and blanking is driven by the horizontal and vertical bits of the sequences found in the luma stream.

The datapath is a four-word look-ahead delay line feeding a state machine. The states are ST_ACT (active or unclassified word), ST_EAV (inside an end-of-active sequence), ST_HBLK (blanking word that is not part of a sequence), ST_SAV (inside a start-of-active sequence) and ST_DTRS (an embedded sequence found in detect mode).

In flag mode the transitions are:
- ST_ACT→ST_EAV when the next word has the horizontal flag set.
- ST_EAV→ST_EAV while the word counter is below 3.
- ST_EAV→ST_SAV or ST_HBLK or ST_ACT after the fourth word, chosen by the look-ahead.
- ST_HBLK→ST_SAV when the horizontal flag of the fifth word ahead is low.
- ST_HBLK→ST_ACT when the horizontal flag drops without that warning.
- ST_SAV→ST_ACT (or ST_EAV if the flag is still high) after its fourth word.

In detect mode the transitions are:
- ST_ACT→ST_DTRS on a 3FFh, 000h, 000h preamble.
- ST_DTRS→ST_DTRS for four words.
- ST_DTRS→ST_ACT when no further preamble follows.

Top module: `trs_inserter`

## Requirements
- R1: In flag mode, the first word with the horizontal flag high after a word with it low starts an end-of-active sequence. That word and the next three are output on both streams as 3FFh, 000h, 000h and the XYZ word with bit 6 = 1.
- R2: In flag mode, the four words just before the first word whose horizontal flag is low are output on both streams as 3FFh, 000h, 000h and the XYZ word with bit 6 = 0. A horizontal blanking run must be at least 8 words long.
- R3: XYZ word layout: bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, bits 1:0 = 0. V and F are taken from the flags that arrive with the XYZ word's own position.
- R4: The F bit of every generated XYZ word equals the field input when proc_en is high, and is 0 when proc_en is low.
- R5: When keep_data is low, every non-sequence word whose horizontal or vertical flag is high is output as 040h on luma and 200h on chroma.
- R6: In flag mode, a non-sequence word passes unchanged when keep_data is high or when both blanking flags are low.
- R7: When trs_detect is high, h_in, v_in and f_in have no effect and no sequence is generated. Embedded sequences (luma 3FFh, 000h, 000h, then one more word) pass unchanged on both streams.
- R8: In detect mode with keep_data low, the words after an embedded XYZ word are blanked as in R5 while that XYZ word's bit 6 or bit 7 is set. Before the first XYZ word after reset, no word is blanked.
- R9: Every output word appears exactly 4 clock cycles after its input word is sampled.
- R10: While reset is asserted, both outputs are 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| y_in | input | DW | Luma word |
| c_in | input | DW | Chroma word |
| h_in | input | 1 | Horizontal blanking flag |
| v_in | input | 1 | Vertical blanking flag |
| f_in | input | 1 | Field flag (high in field 2) |
| proc_en | input | 1 | Enables the F bit in generated XYZ words |
| trs_detect | input | 1 | Take timing from embedded sequences and ignore the flags |
| keep_data | input | 1 | 1 passes blanking samples, 0 replaces them with blanking levels |
| y_out | output | DW | Luma word out |
| c_out | output | DW | Chroma word out |

## Verification
The bench targets the following corner cases:
- A blanking run of exactly eight words, where the end-of-active sequence is directly followed by the start-of-active sequence. A design that triggers the second sequence one word late or early corrupts the first active pixel or the last sequence word.
- Lines whose V and F change from line to line, with proc_en off, which expose a swapped or stale protection bit or a leaked F bit.
- Detect-mode runs with random flag inputs, checking that they cannot create sequences.
- Blanking that switches on only after the embedded XYZ word. A design that applies it one word early would overwrite that XYZ word.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Words in one timing reference sequence: preamble of three plus XYZ.
    localparam int TRS_WORDS = 4;
    localparam int CNT_W     = $clog2(TRS_WORDS);

    typedef enum logic [2:0] {
        ST_ACT,
        ST_EAV,
        ST_HBLK,
        ST_SAV,
        ST_DTRS
    } trs_state_e;

    typedef struct packed {
        logic h;
        logic v;
        logic f;
    } tflag_t;

endpackage

// File: rtl/trs_tap_line.sv
module trs_tap_line
    import trs_pkg::*;
#(
    parameter int DW    = 10,
    parameter int DEPTH = TRS_WORDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DW-1:0]              y_in,
    input  logic [DW-1:0]              c_in,
    input  tflag_t                     fl_in,
    output logic [DEPTH-1:0][DW-1:0]   y_tap,
    output logic [DEPTH-1:0][DW-1:0]   c_tap,
    output tflag_t [DEPTH-1:0]         fl_tap
);

    // Stage 0 is the input itself; stage i+1 is the input i+1 cycles ago.
    logic [DW-1:0] y_stage  [DEPTH+1];
    logic [DW-1:0] c_stage  [DEPTH+1];
    tflag_t        fl_stage [DEPTH+1];

    assign y_stage[0]  = y_in;
    assign c_stage[0]  = c_in;
    assign fl_stage[0] = fl_in;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                y_stage[i+1]  <= '0;
                c_stage[i+1]  <= '0;
                fl_stage[i+1] <= '0;
            end else begin
                y_stage[i+1]  <= y_stage[i];
                c_stage[i+1]  <= c_stage[i];
                fl_stage[i+1] <= fl_stage[i];
            end
        end

        assign y_tap[i]  = y_stage[i+1];
        assign c_tap[i]  = c_stage[i+1];
        assign fl_tap[i] = fl_stage[i+1];
    end

endmodule

// File: rtl/trs_sequencer.sv
module trs_sequencer
    import trs_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trs_detect,
    input  logic                           h_now,
    input  logic [TRS_WORDS-1:0]           h_tap,
    input  logic [TRS_WORDS-1:0][DW-1:0]   y_tap,
    output trs_state_e                     st_d,
    output logic [CNT_W-1:0]               cnt_d,
    output trs_state_e                     st_q,
    output logic [CNT_W-1:0]               cnt_q,
    output logic                           trk_h,
    output logic                           trk_v
);

    localparam int                OLD     = TRS_WORDS - 1;
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(TRS_WORDS - 1);
    localparam int                H_BIT   = DW - 4;
    localparam int                V_BIT   = DW - 3;

    logic h_cur;
    logic sav_start;
    logic preamble;

    // Word being classified is the oldest tap.
    assign h_cur     = h_tap[OLD];
    // Start-of-active begins where the next four words are blanking and the fifth is not.
    assign sav_start = (&h_tap) & ~h_now;
    assign preamble  = (y_tap[OLD] == '1) && (y_tap[OLD-1] == '0) && (y_tap[OLD-2] == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ACT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state decision
    always_comb begin
        st_d  = ST_ACT;
        cnt_d = '0;
        if (trs_detect) begin
            if (st_q == ST_DTRS && cnt_q != LAST) begin
                st_d  = ST_DTRS;
                cnt_d = cnt_q + 1'b1;
            end else if (preamble) begin
                st_d  = ST_DTRS;
            end
        end else begin
            unique case (st_q)
                ST_ACT, ST_DTRS: begin
                    if (h_cur) st_d = ST_EAV;
                end
                ST_EAV: begin
                    if (cnt_q != LAST) begin
                        st_d  = ST_EAV;
                        cnt_d = cnt_q + 1'b1;
                    end else if (sav_start) begin
                        st_d = ST_SAV;
                    end else if (h_cur) begin
                        st_d = ST_HBLK;
                    end
                end
                ST_HBLK: begin
                    if (sav_start)  st_d = ST_SAV;
                    else if (h_cur) st_d = ST_HBLK;
                end
                ST_SAV: begin
                    if (cnt_q != LAST) begin
                        st_d  = ST_SAV;
                        cnt_d = cnt_q + 1'b1;
                    end else if (h_cur) begin
                        st_d = ST_EAV;
                    end
                end
            endcase
        end
    end

    // Blanking flags recovered from embedded XYZ words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_h <= 1'b0;
            trk_v <= 1'b0;
        end else if (trs_detect && st_d == ST_DTRS && cnt_d == LAST) begin
            trk_h <= y_tap[OLD][H_BIT];
            trk_v <= y_tap[OLD][V_BIT];
        end
    end

endmodule

// File: rtl/trs_word_mux.sv
module trs_word_mux
    import trs_pkg::*;
#(
    parameter int             DW      = 10,
    parameter logic [DW-1:0]  Y_BLANK = DW'(10'h040),
    parameter logic [DW-1:0]  C_BLANK = DW'(10'h200)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trs_state_e        st_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic [DW-1:0]     y_cur,
    input  logic [DW-1:0]     c_cur,
    input  tflag_t            fl_cur,
    input  logic              proc_en,
    input  logic              trs_detect,
    input  logic              keep_data,
    input  logic              trk_h,
    input  logic              trk_v,
    output logic [DW-1:0]     y_out,
    output logic [DW-1:0]     c_out
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRS_WORDS - 1);

    logic [DW-1:0] xyz;
    logic [DW-1:0] y_nx;
    logic [DW-1:0] c_nx;
    logic          f_bit;
    logic          h_bit;
    logic          blank_zone;

    assign f_bit = fl_cur.f & proc_en;
    assign h_bit = (st_d == ST_EAV);

    always_comb begin
        xyz        = '0;
        xyz[DW-1]  = 1'b1;
        xyz[DW-2]  = f_bit;
        xyz[DW-3]  = fl_cur.v;
        xyz[DW-4]  = h_bit;
        xyz[DW-5]  = fl_cur.v ^ h_bit;
        xyz[DW-6]  = f_bit ^ h_bit;
        xyz[DW-7]  = f_bit ^ fl_cur.v;
        xyz[DW-8]  = f_bit ^ fl_cur.v ^ h_bit;
    end

    assign blank_zone = trs_detect ? (trk_h | trk_v) : (fl_cur.h | fl_cur.v);

    // Output selection
    always_comb begin
        y_nx = y_cur;
        c_nx = c_cur;
        unique case (st_d)
            ST_EAV, ST_SAV: begin
                if (cnt_d == '0) begin
                    y_nx = '1;
                    c_nx = '1;
                end else if (cnt_d == LAST) begin
                    y_nx = xyz;
                    c_nx = xyz;
                end else begin
                    y_nx = '0;
                    c_nx = '0;
                end
            end
            ST_DTRS: begin
                y_nx = y_cur;
                c_nx = c_cur;
            end
            ST_ACT, ST_HBLK: begin
                if (!keep_data && blank_zone) begin
                    y_nx = Y_BLANK;
                    c_nx = C_BLANK;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out <= '0;
            c_out <= '0;
        end else begin
            y_out <= y_nx;
            c_out <= c_nx;
        end
    end

endmodule

// File: rtl/trs_inserter.sv
module trs_inserter
    import trs_pkg::*;
#(
    parameter int             DW      = 10,
    parameter logic [DW-1:0]  Y_BLANK = DW'(10'h040),
    parameter logic [DW-1:0]  C_BLANK = DW'(10'h200)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  y_in,
    input  logic [DW-1:0]  c_in,
    input  logic           h_in,
    input  logic           v_in,
    input  logic           f_in,
    input  logic           proc_en,
    input  logic           trs_detect,
    input  logic           keep_data,
    output logic [DW-1:0]  y_out,
    output logic [DW-1:0]  c_out
);

    localparam int OLD = TRS_WORDS - 1;

    tflag_t                          fl_in;
    logic [TRS_WORDS-1:0][DW-1:0]    y_tap;
    logic [TRS_WORDS-1:0][DW-1:0]    c_tap;
    tflag_t [TRS_WORDS-1:0]          fl_tap;
    logic [TRS_WORDS-1:0]            h_tap;
    trs_state_e                      st_d;
    trs_state_e                      st_q;
    logic [CNT_W-1:0]                cnt_d;
    logic [CNT_W-1:0]                cnt_q;
    logic                            trk_h;
    logic                            trk_v;

    assign fl_in = '{h: h_in, v: v_in, f: f_in};

    for (genvar i = 0; i < TRS_WORDS; i++) begin : g_htap
        assign h_tap[i] = fl_tap[i].h;
    end

    trs_tap_line #(.DW(DW), .DEPTH(TRS_WORDS)) u_taps (
        .clk    (clk),
        .rst_n  (rst_n),
        .y_in   (y_in),
        .c_in   (c_in),
        .fl_in  (fl_in),
        .y_tap  (y_tap),
        .c_tap  (c_tap),
        .fl_tap (fl_tap)
    );

    trs_sequencer #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trs_detect (trs_detect),
        .h_now      (h_in),
        .h_tap      (h_tap),
        .y_tap      (y_tap),
        .st_d       (st_d),
        .cnt_d      (cnt_d),
        .st_q       (st_q),
        .cnt_q      (cnt_q),
        .trk_h      (trk_h),
        .trk_v      (trk_v)
    );

    trs_word_mux #(.DW(DW), .Y_BLANK(Y_BLANK), .C_BLANK(C_BLANK)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_d       (st_d),
        .cnt_d      (cnt_d),
        .y_cur      (y_tap[OLD]),
        .c_cur      (c_tap[OLD]),
        .fl_cur     (fl_tap[OLD]),
        .proc_en    (proc_en),
        .trs_detect (trs_detect),
        .keep_data  (keep_data),
        .trk_h      (trk_h),
        .trk_v      (trk_v),
        .y_out      (y_out),
        .c_out      (c_out)
    );

endmodule

// File: rtl/trs_inserter_chk.sv
module trs_inserter_chk
    import trs_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_en,
    input  logic              trs_detect,
    input  trs_state_e        st_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [DW-1:0]     y_out,
    input  logic [DW-1:0]     c_out
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRS_WORDS - 1);

    function automatic logic prot_ok(input logic [DW-1:0] w);
        return w[DW-1] &&
               (w[DW-5] == (w[DW-3] ^ w[DW-4])) &&
               (w[DW-6] == (w[DW-2] ^ w[DW-4])) &&
               (w[DW-7] == (w[DW-2] ^ w[DW-3])) &&
               (w[DW-8] == (w[DW-2] ^ w[DW-3] ^ w[DW-4])) &&
               (w[DW-9] == 1'b0) && (w[DW-10] == 1'b0);
    endfunction

    // R1 R2
    preamble_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_EAV || st_q == ST_SAV) && cnt_q == '0) |-> (y_out == '1 && c_out == '1));

    // R1
    eav_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EAV && cnt_q != LAST) |=> (st_q == ST_EAV && cnt_q == $past(cnt_q) + 1'b1));

    // R3
    eav_xyz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EAV && cnt_q == LAST) |-> (y_out[DW-4] && prot_ok(y_out) && c_out == y_out));

    // R3
    sav_xyz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAV && cnt_q == LAST) |-> (!y_out[DW-4] && prot_ok(y_out) && c_out == y_out));

    // R4
    fbit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_EAV || st_q == ST_SAV) && cnt_q == LAST && !$past(proc_en)) |-> !y_out[DW-2]);

    // R7
    detect_no_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trs_detect) |-> (st_q == ST_ACT || st_q == ST_DTRS));

    // R10
    reset_zero_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (y_out == '0 && c_out == '0));

endmodule

bind trs_inserter trs_inserter_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_en    (proc_en),
    .trs_detect (trs_detect),
    .st_q       (st_q),
    .cnt_q      (cnt_q),
    .y_out      (y_out),
    .c_out      (c_out)
);

// File: tb/tb_trs_inserter.sv
`timescale 1ns/1ps
module tb_trs_inserter;

    localparam int MAXN = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] y_in = '0, c_in = '0;
    logic       h_in = 1'b0, v_in = 1'b0, f_in = 1'b0;
    logic       proc_en = 1'b0, trs_detect = 1'b0, keep_data = 1'b0;
    logic [9:0] y_out, c_out;

    always #2.5 clk = ~clk;

    trs_inserter dut (
        .clk(clk), .rst_n(rst_n), .y_in(y_in), .c_in(c_in),
        .h_in(h_in), .v_in(v_in), .f_in(f_in), .proc_en(proc_en),
        .trs_detect(trs_detect), .keep_data(keep_data),
        .y_out(y_out), .c_out(c_out)
    );

    logic [9:0] sy [MAXN];
    logic [9:0] sc [MAXN];
    bit         sh [MAXN];
    bit         sv [MAXN];
    bit         sf [MAXN];
    logic [9:0] ey [MAXN];
    logic [9:0] ec [MAXN];
    string      etag [MAXN];
    int         n_words;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;
    int unsigned seed = 32'h2468ace1;

    function automatic int unsigned next_rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    // Data words stay below 3FFh so that they never form a preamble.
    function automatic logic [9:0] rnd_word();
        return 10'(1 + (next_rnd() % 1000));
    endfunction

    function automatic logic [9:0] xyz_of(bit f, bit v, bit h);
        logic [9:0] w;
        w = 10'h200;
        if (f) w = w | 10'h100;
        if (v) w = w | 10'h080;
        if (h) w = w | 10'h040;
        if (v != h) w = w | 10'h020;
        if (f != h) w = w | 10'h010;
        if (f != v) w = w | 10'h008;
        if ((f + v + h) % 2 == 1) w = w | 10'h004;
        return w;
    endfunction

    function automatic logic [9:0] y_at(int p);
        return (p < n_words) ? sy[p] : 10'h000;
    endfunction

    task automatic push(logic [9:0] y, logic [9:0] c, bit h, bit v, bit f);
        sy[n_words] = y; sc[n_words] = c;
        sh[n_words] = h; sv[n_words] = v; sf[n_words] = f;
        n_words++;
    endtask

    task automatic ext_line(int blk, int act, bit v, bit f);
        for (int i = 0; i < blk; i++) push(rnd_word(), rnd_word(), 1'b1, v, f);
        for (int i = 0; i < act; i++) push(rnd_word(), rnd_word(), 1'b0, v, f);
    endtask

    // Stream with its own sequences; flag inputs carry noise.
    task automatic det_line(int blk, int act, bit v, bit f);
        logic [9:0] pre [3] = '{10'h3FF, 10'h000, 10'h000};
        for (int i = 0; i < 3; i++) push(pre[i], pre[i], next_rnd() % 2, next_rnd() % 2, next_rnd() % 2);
        push(xyz_of(f, v, 1'b1), xyz_of(f, v, 1'b1), 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < blk; i++) push(rnd_word(), rnd_word(), next_rnd() % 2, next_rnd() % 2, 1'b0);
        for (int i = 0; i < 3; i++) push(pre[i], pre[i], 1'b1, 1'b0, next_rnd() % 2);
        push(xyz_of(f, v, 1'b0), xyz_of(f, v, 1'b0), 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < act; i++) push(rnd_word(), rnd_word(), next_rnd() % 2, next_rnd() % 2, next_rnd() % 2);
    endtask

    // Behavioural expectation for the flag-driven mode (R1..R6)
    task automatic model_ext(bit pen, bit keep);
        for (int p = 0; p < n_words; p++) begin
            int k = -1;
            int j = -1;
            if (sh[p]) begin
                int r = p;
                while (r > 0 && sh[r-1]) r--;
                if (p - r < 4) k = p - r;
                if (k < 0) begin
                    int s = p + 1;
                    while (s < n_words && sh[s]) s++;
                    if (s - p <= 4) j = 4 - (s - p);
                end
            end
            if (k >= 0 || j >= 0) begin
                int idx = (k >= 0) ? k : j;
                logic [9:0] w;
                w = (idx == 0) ? 10'h3FF : (idx == 3) ? xyz_of(pen & sf[p], sv[p], k >= 0) : 10'h000;
                ey[p] = w; ec[p] = w;
                if (idx == 3) etag[p] = pen ? "R3" : "R4";
                else          etag[p] = (k >= 0) ? "R1" : "R2";
            end else if (!keep && (sh[p] || sv[p])) begin
                ey[p] = 10'h040; ec[p] = 10'h200; etag[p] = "R5";
            end else begin
                ey[p] = sy[p]; ec[p] = sc[p]; etag[p] = "R6";
            end
        end
    endtask

    // Behavioural expectation for detect mode (R7, R8)
    task automatic model_det(bit keep);
        int t = -1;
        bit th = 0, tv = 0;
        for (int p = 0; p < n_words; p++) begin
            if (t >= 0 && t < 3) t++;
            else if (sy[p] == 10'h3FF && y_at(p+1) == 10'h000 && y_at(p+2) == 10'h000) t = 0;
            else t = -1;
            if (t >= 0) begin
                ey[p] = sy[p]; ec[p] = sc[p]; etag[p] = "R7";
                if (t == 3) begin th = sy[p][6]; tv = sy[p][7]; end
            end else if (!keep && (th || tv)) begin
                ey[p] = 10'h040; ec[p] = 10'h200; etag[p] = "R8";
            end else begin
                ey[p] = sy[p]; ec[p] = sc[p]; etag[p] = "R7";
            end
        end
    endtask

    task automatic check_word(int p);
        checks++;
        if (y_out !== ey[p] || c_out !== ec[p]) begin
            errors++;
            $display("FAIL %s/R9 word %0d: actual y=%03h c=%03h expected y=%03h c=%03h",
                     etag[p], p, y_out, c_out, ey[p], ec[p]);
        end
    endtask

    task automatic run_phase(bit det, bit pen, bit keep);
        @(negedge clk);
        rst_n = 1'b0;
        y_in = '0; c_in = '0; h_in = 0; v_in = 0; f_in = 0;
        trs_detect = det; proc_en = pen; keep_data = keep;
        repeat (3) @(negedge clk);
        checks++;
        if (y_out !== 10'h000 || c_out !== 10'h000) begin
            errors++;
            $display("FAIL R10 reset: actual y=%03h c=%03h expected y=000 c=000", y_out, c_out);
        end
        rst_n = 1'b1;
        for (int n = 0; n < n_words + 4; n++) begin
            if (n < n_words) begin
                y_in = sy[n]; c_in = sc[n]; h_in = sh[n]; v_in = sv[n]; f_in = sf[n];
            end else begin
                y_in = '0; c_in = '0; h_in = 0; v_in = 0; f_in = 0;
            end
            @(negedge clk);
            // R9: the word sampled four edges ago is now at the output
            if (n >= 4) check_word(n - 4);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Phase 1: flag mode, F enabled, blanking replaced
        n_words = 0;
        for (int i = 0; i < 5; i++) push(rnd_word(), rnd_word(), 0, 0, 0);
        ext_line(10, 12, 0, 0);
        ext_line(10, 12, 1, 0);
        ext_line(8, 12, 1, 1);
        ext_line(9, 16, 0, 1);
        model_ext(1, 0);
        run_phase(0, 1, 0);

        // Phase 2: F gated off, blanking data kept
        n_words = 0;
        for (int i = 0; i < 3; i++) push(rnd_word(), rnd_word(), 0, 1, 1);
        ext_line(12, 10, 1, 1);
        ext_line(8, 14, 0, 1);
        ext_line(11, 9, 1, 0);
        model_ext(0, 1);
        run_phase(0, 0, 1);

        // Phase 3: minimum and long blanking, data kept, F enabled
        n_words = 0;
        for (int i = 0; i < 6; i++) push(rnd_word(), rnd_word(), 0, 0, 1);
        ext_line(8, 8, 0, 1);
        ext_line(20, 6, 1, 1);
        ext_line(8, 20, 1, 0);
        model_ext(1, 1);
        run_phase(0, 1, 1);

        // Phase 4: detect mode with blanking replaced
        n_words = 0;
        for (int i = 0; i < 6; i++) push(rnd_word(), rnd_word(), 1, 1, 1);
        det_line(6, 10, 0, 0);
        det_line(5, 8, 1, 1);
        det_line(7, 9, 0, 1);
        model_det(0);
        run_phase(1, 1, 0);

        // Phase 5: detect mode with data kept
        n_words = 0;
        for (int i = 0; i < 4; i++) push(rnd_word(), rnd_word(), 1, 0, 0);
        det_line(6, 6, 1, 0);
        det_line(4, 10, 0, 0);
        model_det(1);
        run_phase(1, 0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule